// File: doc/BRIEF.md
# Cross-Coupled Byte Mailbox With Notify Lines

This block joins two processors, called the left side and the right side, through two one-byte mailboxes that cross between them. Each side has its own small bus: a select, a read strobe, a write strobe, a write-data byte and a read-data byte. A byte written by one side lands in a register that only the other side can read. A side never reads back what it wrote itself.

Every access also moves a notify line, active low, that runs to the processor on the other side. A write drives it low, so the receiver can take it as an interrupt or a counter trigger. A read drives it high again, which tells the writer that its message was collected. Each notify line is moved only by the side opposite its receiver, so accesses from both sides in the same cycle never contend. Strobes are one-cycle pulses on a shared clock. A read presents its byte in the same cycle as its strobe, and a write takes effect at the following clock edge.

Top module: `mbx_dual_top`

## Requirements
- R1: While `rst_n` is low, and after any reset, both mailbox registers hold 0x00 and both notify outputs (`l_notify_n`, `r_notify_n`) are high.
- R2: A left write (`l_cs`=1, `l_wr`=1) stores `l_wdata` at the clock edge, and every later right read returns that byte until the left side writes again.
- R3: A right write (`r_cs`=1, `r_wr`=1) stores `r_wdata` at the clock edge, and every later left read returns that byte until the right side writes again.
- R4: During a left read (`l_cs`=1, `l_rd`=1), `l_rdata` shows the byte last written by the right side, in the same cycle as the strobe.
- R5: During a right read (`r_cs`=1, `r_rd`=1), `r_rdata` shows the byte last written by the left side, in the same cycle as the strobe.
- R6: After the clock edge that ends a left write, `r_notify_n` is low. After the clock edge that ends a left read without a write, `r_notify_n` is high.
- R7: After the clock edge that ends a right write, `l_notify_n` is low. After the clock edge that ends a right read without a write, `l_notify_n` is high.
- R8: A cycle in which a side's select is low, or neither of its strobes is high, changes neither that side's mailbox register nor the notify line that the side drives.
- R9: When one side raises read and write in the same cycle, both take place. The read returns the other side's byte, the write stores the new byte, and the notify line ends low because the write takes priority.
- R10: When both sides access in the same cycle, both accesses complete. A read that meets a write from the other side in that cycle returns the value held before the write.
- R11: When its side is not reading, each read-data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| l_cs | input | 1 | Left side mailbox select |
| l_rd | input | 1 | Left side read strobe, one cycle |
| l_wr | input | 1 | Left side write strobe, one cycle |
| l_wdata | input | DATA_W | Byte written by the left side |
| l_rdata | output | DATA_W | Byte read by the left side (last right write) |
| l_notify_n | output | 1 | Active-low notify to the left processor, moved by right accesses |
| r_cs | input | 1 | Right side mailbox select |
| r_rd | input | 1 | Right side read strobe, one cycle |
| r_wr | input | 1 | Right side write strobe, one cycle |
| r_wdata | input | DATA_W | Byte written by the right side |
| r_rdata | output | DATA_W | Byte read by the right side (last left write) |
| r_notify_n | output | 1 | Active-low notify to the right processor, moved by left accesses |

## Verification
The assertions assume that every input is synchronous to `clk`, that a strobe lasts one cycle, and that no access arrives while the internal reset is held, which is the two edges after `rst_n` rises. The bench drives every strobe one nanosecond after a rising edge and drops it at the next edge. After each reset it waits several cycles before the first access. The bench covers lone strobes, strobes with the select low, read and write raised together on one side, and accesses from both sides in the same cycle. In each case it predicts both read-data bytes and both notify lines from its own model of the two mailboxes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Kind of access seen on one side in a cycle; write outranks read.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } mbx_acc_e;

  // Number of ports joined by the mailbox pair.
  localparam int unsigned MBX_SIDES = 2;

  function automatic mbx_acc_e mbx_decode(input logic sel, input logic rd, input logic wr);
    mbx_acc_e kind;
    if (!sel)     kind = ACC_IDLE;
    else if (wr)  kind = ACC_WRITE;
    else if (rd)  kind = ACC_READ;
    else          kind = ACC_IDLE;
    return kind;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
// Reset conditioner: the reset takes effect at once, and its release waits for STAGES clock edges.
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/mbx_side.sv
// One side of the cross-coupled mailbox: the register this side writes,
// the notify line toward the opposite processor, and the read mux that
// shows the opposite side's register.
module mbx_side
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] peer_q,
  output logic [DATA_W-1:0] mbox_q,
  output logic [DATA_W-1:0] rdata,
  output logic              notify_n
);

  mbx_acc_e          acc;
  logic              mbox_en;
  logic [DATA_W-1:0] mbox_d;
  logic              notify_en;
  logic              notify_d;
  logic              rd_en;

  // Next-state logic
  always_comb begin
    acc       = mbx_decode(sel, rd, wr);
    mbox_en   = (acc == ACC_WRITE);
    mbox_d    = wdata;
    notify_en = (acc != ACC_IDLE);
    notify_d  = (acc == ACC_READ);
    rd_en     = sel && rd;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mbox_q <= '0;
    else if (mbox_en) mbox_q <= mbox_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         notify_n <= 1'b1;
    else if (notify_en) notify_n <= notify_d;
  end

  // Same-cycle read path
  always_comb begin
    rdata = rd_en ? peer_q : '0;
  end

  // The left instance covers R6, the right instance covers R7.
  a_r6_r7_write_drives_low : assert property (
    @(posedge clk) disable iff (!rst_n)
    (sel && wr) |=> !notify_n
  ) else $error("write did not pull notify low");

  a_r6_r7_read_drives_high : assert property (
    @(posedge clk) disable iff (!rst_n)
    (sel && rd && !wr) |=> notify_n
  ) else $error("read did not release notify");

  // The left instance covers R2, the right instance covers R3.
  a_r2_r3_write_stores : assert property (
    @(posedge clk) disable iff (!rst_n)
    (sel && wr) |=> (mbox_q == $past(wdata))
  ) else $error("written byte not stored");

  a_r8_idle_holds : assert property (
    @(posedge clk) disable iff (!rst_n)
    !(sel && (rd || wr)) |=> ($stable(mbox_q) && $stable(notify_n))
  ) else $error("idle cycle changed state");

endmodule

// File: rtl/mbx_dual_top.sv
module mbx_dual_top
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs,
  input  logic              l_rd,
  input  logic              l_wr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_notify_n,
  input  logic              r_cs,
  input  logic              r_rd,
  input  logic              r_wr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_notify_n
);

  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;

  logic              rst_int_n;
  logic              sd_sel   [MBX_SIDES];
  logic              sd_rd    [MBX_SIDES];
  logic              sd_wr    [MBX_SIDES];
  logic [DATA_W-1:0] sd_wdata [MBX_SIDES];
  logic [DATA_W-1:0] sd_mbox  [MBX_SIDES];
  logic [DATA_W-1:0] sd_rdata [MBX_SIDES];
  logic              sd_note  [MBX_SIDES];

  mbx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    sd_sel[LEFT]    = l_cs;
    sd_rd[LEFT]     = l_rd;
    sd_wr[LEFT]     = l_wr;
    sd_wdata[LEFT]  = l_wdata;
    sd_sel[RIGHT]   = r_cs;
    sd_rd[RIGHT]    = r_rd;
    sd_wr[RIGHT]    = r_wr;
    sd_wdata[RIGHT] = r_wdata;
  end

  // Each side reads the register of the opposite side.
  for (genvar g = 0; g < MBX_SIDES; g++) begin : g_side
    localparam int unsigned PEER = MBX_SIDES - 1 - g;
    mbx_side #(.DATA_W(DATA_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .sel      (sd_sel[g]),
      .rd       (sd_rd[g]),
      .wr       (sd_wr[g]),
      .wdata    (sd_wdata[g]),
      .peer_q   (sd_mbox[PEER]),
      .mbox_q   (sd_mbox[g]),
      .rdata    (sd_rdata[g]),
      .notify_n (sd_note[g])
    );
  end

  // A side's notify output is the line moved by the opposite side.
  assign l_rdata    = sd_rdata[LEFT];
  assign r_rdata    = sd_rdata[RIGHT];
  assign r_notify_n = sd_note[LEFT];
  assign l_notify_n = sd_note[RIGHT];

  a_r5_cross_left_to_right : assert property (
    @(posedge clk) disable iff (!rst_int_n)
    ($past(l_cs && l_wr) && r_cs && r_rd) |-> (r_rdata == $past(l_wdata))
  ) else $error("right read missed fresh left byte");

  a_r4_cross_right_to_left : assert property (
    @(posedge clk) disable iff (!rst_int_n)
    ($past(r_cs && r_wr) && l_cs && l_rd) |-> (l_rdata == $past(r_wdata))
  ) else $error("left read missed fresh right byte");

  a_r11_idle_rdata_zero : assert property (
    @(posedge clk) disable iff (!rst_int_n)
    (!(l_cs && l_rd) && !(r_cs && r_rd)) |-> ((l_rdata == '0) && (r_rdata == '0))
  ) else $error("read data not zero while idle");

  a_r1_release_inactive : assert property (
    @(posedge clk)
    $rose(rst_int_n) |-> (l_notify_n && r_notify_n)
  ) else $error("notify active at reset release");

endmodule

// File: tb/mbx_dual_top_tb.sv
module mbx_dual_top_tb;

  localparam int DW = 8;
  localparam int SIG_LRD  = 0;
  localparam int SIG_RRD  = 1;
  localparam int SIG_LNOT = 2;
  localparam int SIG_RNOT = 3;

  typedef struct {
    int          cyc;
    int          sig;
    logic [7:0]  exp;
    string       req;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          l_cs, l_rd, l_wr, r_cs, r_rd, r_wr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic          l_notify_n, r_notify_n;

  int    cyc;
  int    n_checks;
  int    n_fail;
  bit    done;
  item_t sb[$];

  // Bench model of the mailboxes and notify lines
  logic [7:0] m_l2r, m_r2l;
  logic       m_lnot, m_rnot;

  mbx_dual_top #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs(l_cs), .l_rd(l_rd), .l_wr(l_wr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_notify_n(l_notify_n),
    .r_cs(r_cs), .r_rd(r_rd), .r_wr(r_wr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_notify_n(r_notify_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(input int c, input int s, input logic [7:0] e, input string r);
    item_t it;
    it.cyc = c; it.sig = s; it.exp = e; it.req = r;
    sb.push_back(it);
  endtask

  function automatic logic [7:0] actual(input int s);
    case (s)
      SIG_LRD:  return l_rdata;
      SIG_RRD:  return r_rdata;
      SIG_LNOT: return {7'd0, l_notify_n};
      default:  return {7'd0, r_notify_n};
    endcase
  endfunction

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      item_t it;
      logic [7:0] a;
      it = sb.pop_front();
      a  = actual(it.sig);
      n_checks++;
      if (it.cyc != cyc || a !== it.exp) begin
        n_fail++;
        $display("FAIL %s: signal %0d cycle %0d actual %02h expected %02h",
                 it.req, it.sig, cyc, a, it.exp);
      end
    end
  end

  task automatic idle_inputs();
    l_cs = 0; l_rd = 0; l_wr = 0; l_wdata = '0;
    r_cs = 0; r_rd = 0; r_wr = 0; r_wdata = '0;
  endtask

  task automatic do_reset(input string r);
    @(posedge clk); #1;
    idle_inputs();
    rst_n = 1'b0;
    m_l2r = 8'h00; m_r2l = 8'h00; m_lnot = 1'b1; m_rnot = 1'b1;
    push(cyc, SIG_LNOT, 8'h01, r);
    push(cyc, SIG_RNOT, 8'h01, r);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // Driver: one cycle of stimulus on both sides, expectations from the model.
  task automatic access(input logic lc, input logic lr, input logic lw, input logic [7:0] ld,
                        input logic rc, input logic rr, input logic rw, input logic [7:0] rd,
                        input string r);
    int c;
    @(posedge clk); #1;
    c = cyc;
    l_cs = lc; l_rd = lr; l_wr = lw; l_wdata = ld;
    r_cs = rc; r_rd = rr; r_wr = rw; r_wdata = rd;
    push(c, SIG_LRD, (lc && lr) ? m_r2l : 8'h00, r);
    push(c, SIG_RRD, (rc && rr) ? m_l2r : 8'h00, r);
    if (lc && lw)      begin m_l2r = ld; m_rnot = 1'b0; end
    else if (lc && lr) m_rnot = 1'b1;
    if (rc && rw)      begin m_r2l = rd; m_lnot = 1'b0; end
    else if (rc && rr) m_lnot = 1'b1;
    push(c + 1, SIG_LNOT, {7'd0, m_lnot}, r);
    push(c + 1, SIG_RNOT, {7'd0, m_rnot}, r);
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
    end
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    idle_inputs();
    rst_n = 1'b0;
    m_l2r = 8'h00; m_r2l = 8'h00; m_lnot = 1'b1; m_rnot = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state seen through idle outputs and reads of both registers
    access(0,0,0,8'h00, 0,0,0,8'h00, "R1");
    access(1,1,0,8'h00, 1,1,0,8'h00, "R1");

    // R2, R6: left write stores a byte and pulls the right notify low
    access(1,0,1,8'hA5, 0,0,0,8'h00, "R6");
    // R5, R7: right read returns it and releases the left notify
    access(0,0,0,8'h00, 1,1,0,8'h00, "R5");
    access(0,0,0,8'h00, 1,1,0,8'h00, "R2");
    // R6: left read releases the right notify
    access(1,1,0,8'h00, 0,0,0,8'h00, "R6");

    // R3, R7: right write stores and pulls the left notify low
    access(0,0,0,8'h00, 1,0,1,8'h3C, "R7");
    access(1,1,0,8'h00, 0,0,0,8'h00, "R4");
    access(1,1,0,8'h00, 0,0,0,8'h00, "R3");
    access(0,0,0,8'h00, 1,1,0,8'h00, "R7");

    // R8: strobes with select low, and select without strobes
    access(0,1,1,8'hFF, 0,1,1,8'hEE, "R8");
    access(1,0,0,8'h77, 1,0,0,8'h66, "R8");
    access(1,1,0,8'h00, 1,1,0,8'h00, "R8");

    // R9: read and write together on one side
    access(1,1,1,8'h5A, 0,0,0,8'h00, "R9");
    access(0,0,0,8'h00, 1,1,1,8'hC3, "R9");
    access(1,1,0,8'h00, 1,1,0,8'h00, "R9");

    // R10: both sides in the same cycle, reads see the old bytes
    access(1,0,1,8'h11, 1,1,0,8'h00, "R10");
    access(1,1,0,8'h00, 1,0,1,8'h22, "R10");
    access(1,0,1,8'h33, 1,0,1,8'h44, "R10");
    access(1,1,0,8'h00, 1,1,0,8'h00, "R10");

    // R11: read data stays zero while writes happen without reads
    access(1,0,1,8'h81, 1,0,1,8'h7E, "R11");

    // R2, R3, R4, R5: a spread of byte patterns
    for (int i = 0; i < 12; i++) begin
      access(1,0,1,8'(i*37+1), 0,0,0,8'h00, "R2");
      access(0,0,0,8'h00, 1,0,1,8'(8'hFF - i*19), "R3");
      access(1,1,0,8'h00, 1,1,0,8'h00, "R4");
    end

    // R1: reset in mid-run clears both registers
    access(1,0,1,8'hDE, 1,0,1,8'hAD, "R1");
    do_reset("R1");
    access(1,1,0,8'h00, 1,1,0,8'h00, "R1");

    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end

endmodule